// File: doc/BRIEF.md
# Bouncing Ball Sprite Renderer

This block paints a square white ball on a black screen. It is clocked by the pixel clock and receives the coordinate of the pixel currently being scanned, with an 11-bit horizontal and a 10-bit vertical value. It returns one 24-bit colour for that pixel, registered one clock after the coordinate is presented. Sync generation, blanking and line encoding belong to the surrounding display pipeline.

The ball's top-left corner and its velocity are kept per axis in registers. They advance once per frame, on the clock where the scan coordinate is (0,0). Each axis moves by a fixed signed step. When a move would reach or pass an edge, the position is clamped to that edge and the sign of that axis's step is reversed in the same update. Each axis reflects on its own, so a corner hit reverses both. Ball size, start position and step sizes are parameters.

Top module: `bounce_ball_renderer`

## Requirements
- R1: One clock after a coordinate (x,y) is presented, `rgb` is 24'hFFFFFF when bx <= x < bx+BALL_SIZE and by <= y < by+BALL_SIZE, and 24'h000000 otherwise. Here (bx,by) is the ball position held during that clock.
- R2: While `rst_n` is low at a clock edge, `rgb` becomes 0, the ball moves to (START_X, START_Y) and both velocities become positive (+SPEED_X, +SPEED_Y).
- R3: The ball position and velocity change only on a clock where pix_x = 0 and pix_y = 0. Any other coordinate, including x = 0 alone or y = 0 alone, leaves them unchanged.
- R4: On an update with positive horizontal velocity v, the new x is bx+v when bx+v < H_ACTIVE-BALL_SIZE. Otherwise x becomes H_ACTIVE-BALL_SIZE and the velocity becomes -v.
- R5: On an update with negative horizontal velocity v, the new x is bx+v when bx+v > 0. Otherwise x becomes 0 and the velocity becomes -v.
- R6: The vertical axis follows the same rule as R4 and R5 against the limits 0 and V_ACTIVE-BALL_SIZE, independently of the horizontal axis.
- R7: When both axes reach an edge on the same update, both velocities reverse on that update.
- R8: The magnitude of each velocity always equals its parameter speed.
- R9: The ball position never exceeds H_ACTIVE-BALL_SIZE horizontally or V_ACTIVE-BALL_SIZE vertically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | 11 | Horizontal coordinate of the scanned pixel |
| pix_y | input | 10 | Vertical coordinate of the scanned pixel |
| rgb | output | 24 | Pixel colour, one clock after the coordinate |

## Verification
Eight probe points are taken around the ball's expected corner after every frame step. Points just inside and just outside each side show whether the ball has moved by exactly one step and whether the lit region is off by one pixel. Runs of 40 frames carry the ball into all four walls at different times. A second instance, whose two axes meet their edges on the same frame, separates a true corner bounce from reversing one axis at a time. Whole-frame scans count mismatches, which catches stray lit pixels anywhere on the screen. Holding x = 0 or y = 0 alone for many clocks shows that only the exact origin advances the ball.

// File: rtl/ball_pkg.sv
`timescale 1ns/1ps
// ball_pkg: coordinate widths and colour constants shared by the renderer.
// Assumes an 11-bit horizontal and a 10-bit vertical scan coordinate.
package ball_pkg;
    localparam int XW = 11;
    localparam int YW = 10;
    localparam int RGBW = 24;
    typedef logic [RGBW-1:0] rgb_t;
    localparam rgb_t WHITE = '1;
    localparam rgb_t BLACK = '0;
endpackage

// File: rtl/ball_axis.sv
`timescale 1ns/1ps
// ball_axis: position and signed velocity of the ball along one axis.
// On each step it moves by the velocity. A move that reaches or passes
// an edge is clamped to that edge and the velocity is negated.
// Assumes 0 < SPEED, SIZE < ACTIVE and START <= ACTIVE - SIZE.
module ball_axis #(
    parameter int W      = 11,
    parameter int ACTIVE = 1280,
    parameter int SIZE   = 32,
    parameter int START  = 100,
    parameter int SPEED  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] pos
);
    localparam int LIMIT = ACTIVE - SIZE;
    localparam int VW    = W + 2;
    localparam logic signed [VW-1:0] LIM_S = VW'(LIMIT);
    localparam logic signed [VW-1:0] SPD_S = VW'(SPEED);

    logic [W-1:0]           pos_q, pos_d;
    logic signed [VW-1:0]   vel_q, vel_d;
    logic signed [VW-1:0]   sum;

    // Next position and velocity, including edge clamp and reflection.
    always_comb begin
        sum   = $signed({2'b00, pos_q}) + vel_q;
        pos_d = pos_q;
        vel_d = vel_q;
        if (step) begin
            if (!vel_q[VW-1]) begin
                if (sum >= LIM_S) begin
                    pos_d = W'(LIMIT);
                    vel_d = -vel_q;
                end else begin
                    pos_d = sum[W-1:0];
                end
            end else begin
                if (sum <= 0) begin
                    pos_d = '0;
                    vel_d = -vel_q;
                end else begin
                    pos_d = sum[W-1:0];
                end
            end
        end
    end

    // State register with synchronous reset to the start point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= W'(START);
            vel_q <= SPD_S;
        end else begin
            pos_q <= pos_d;
            vel_q <= vel_d;
        end
    end

    assign pos = pos_q;

    // R8
    speed_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vel_q == SPD_S) || (vel_q == -SPD_S));
    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= W'(LIMIT));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos_q) && $stable(vel_q));
    // R4
    flip_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(vel_q) || (pos_q == '0) || (pos_q == W'(LIMIT)));
endmodule

// File: rtl/ball_span.sv
`timescale 1ns/1ps
// ball_span: tells whether a coordinate falls inside [pos, pos+SIZE).
// Purely combinational. The compare is one bit wider so that pos+SIZE
// cannot wrap.
module ball_span #(
    parameter int W    = 11,
    parameter int SIZE = 32
) (
    input  logic [W-1:0] coord,
    input  logic [W-1:0] pos,
    output logic         hit
);
    logic [W:0] lo, hi, c;

    // Range compare against the sprite's extent on this axis.
    always_comb begin
        c   = {1'b0, coord};
        lo  = {1'b0, pos};
        hi  = lo + (W+1)'(SIZE);
        hit = (c >= lo) && (c < hi);
    end
endmodule

// File: rtl/bounce_ball_renderer.sv
`timescale 1ns/1ps
// bounce_ball_renderer: white square ball on black, moving one step per
// frame and reflecting off the edges of the active area.
// Assumes the scan visits (0,0) once per frame. The colour is registered
// and appears one clock after its coordinate.
module bounce_ball_renderer
    import ball_pkg::*;
#(
    parameter int H_ACTIVE  = 1280,
    parameter int V_ACTIVE  = 720,
    parameter int BALL_SIZE = 32,
    parameter int START_X   = 100,
    parameter int START_Y   = 100,
    parameter int SPEED_X   = 4,
    parameter int SPEED_Y   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XW-1:0]   pix_x,
    input  logic [YW-1:0]   pix_y,
    output logic [RGBW-1:0] rgb
);
    logic          frame_step;
    logic [XW-1:0] ball_x;
    logic [YW-1:0] ball_y;
    logic          hit_x, hit_y;
    rgb_t          rgb_q;

    // Frame boundary: the scan is at the origin.
    assign frame_step = (pix_x == '0) && (pix_y == '0);

    ball_axis #(.W(XW), .ACTIVE(H_ACTIVE), .SIZE(BALL_SIZE),
                .START(START_X), .SPEED(SPEED_X)) u_axis_x (
        .clk(clk), .rst_n(rst_n), .step(frame_step), .pos(ball_x));

    ball_axis #(.W(YW), .ACTIVE(V_ACTIVE), .SIZE(BALL_SIZE),
                .START(START_Y), .SPEED(SPEED_Y)) u_axis_y (
        .clk(clk), .rst_n(rst_n), .step(frame_step), .pos(ball_y));

    ball_span #(.W(XW), .SIZE(BALL_SIZE)) u_span_x (
        .coord(pix_x), .pos(ball_x), .hit(hit_x));

    ball_span #(.W(YW), .SIZE(BALL_SIZE)) u_span_y (
        .coord(pix_y), .pos(ball_y), .hit(hit_y));

    // Output colour register: white inside the ball, black elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) rgb_q <= BLACK;
        else        rgb_q <= (hit_x && hit_y) ? WHITE : BLACK;
    end

    assign rgb = rgb_q;

    // R1
    two_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_q == WHITE) || (rgb_q == BLACK));
endmodule

// File: tb/test_bounce_ball_renderer.sv
`timescale 1ns/1ps
module test_bounce_ball_renderer;
    localparam int MH = 64, MV = 48, SZ = 8;
    localparam int MSX = 10, MSY = 20, MVX = 5, MVY = 3;
    localparam int CH = 40, CV = 40, CSX = 2, CSY = 2, CVX = 3, CVY = 3;

    // Probe table: offset from ball corner (dx, dy) and expected lit flag.
    localparam int NPROBE = 8;
    localparam int PROBE [NPROBE][3] = '{
        '{0, 0, 1}, '{7, 7, 1}, '{7, 0, 1}, '{0, 7, 1},
        '{8, 3, 0}, '{-1, 3, 0}, '{3, 8, 0}, '{3, -1, 0}};

    logic        clk = 0;
    logic        rst_n = 0;
    logic [10:0] pix_x = 11'd5;
    logic [9:0]  pix_y = 10'd5;
    logic [23:0] rgb_m, rgb_c;

    int checks = 0, fails = 0;
    bit done = 0;
    int mx, my, mvx, mvy, cx, cy, cvx, cvy;

    always #2.5 clk = ~clk;

    bounce_ball_renderer #(.H_ACTIVE(MH), .V_ACTIVE(MV), .BALL_SIZE(SZ),
        .START_X(MSX), .START_Y(MSY), .SPEED_X(MVX), .SPEED_Y(MVY))
        i_bounce_ball_renderer (.clk(clk), .rst_n(rst_n), .pix_x(pix_x),
        .pix_y(pix_y), .rgb(rgb_m));

    bounce_ball_renderer #(.H_ACTIVE(CH), .V_ACTIVE(CV), .BALL_SIZE(SZ),
        .START_X(CSX), .START_Y(CSY), .SPEED_X(CVX), .SPEED_Y(CVY))
        i_bounce_ball_renderer_corner (.clk(clk), .rst_n(rst_n), .pix_x(pix_x),
        .pix_y(pix_y), .rgb(rgb_c));

    task automatic check(input bit ok, input string tag,
                         input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Model of one axis update from R4/R5/R6; returns 1 on reflection.
    function automatic bit advance(inout int p, inout int v, input int lim);
        int s = p + v;
        if (v > 0 && s >= lim) begin p = lim; v = -v; return 1; end
        if (v < 0 && s <= 0)   begin p = 0;   v = -v; return 1; end
        p = s;
        return 0;
    endfunction

    task automatic model_reset();
        mx = MSX; my = MSY; mvx = MVX; mvy = MVY;
        cx = CSX; cy = CSY; cvx = CVX; cvy = CVY;
    endtask

    task automatic probe(input bit corner, input string tag);
        for (int i = 0; i < NPROBE; i++) begin
            int px = (corner ? cx : mx) + PROBE[i][0];
            int py = (corner ? cy : my) + PROBE[i][1];
            logic [23:0] exp, got;
            if (px < 0 || py < 0 || (px == 0 && py == 0)) continue;
            @(negedge clk);
            pix_x = 11'(px);
            pix_y = 10'(py);
            @(negedge clk);
            got = corner ? rgb_c : rgb_m;
            exp = PROBE[i][2] != 0 ? 24'hFFFFFF : 24'h0;
            check(got == exp, tag, got, exp);
        end
    endtask

    // One frame update: present the origin for one clock.
    task automatic frame(output string tm, output string tc);
        bit fx, fy, gx, gy;
        int oldvx = mvx;
        @(negedge clk);
        pix_x = 0; pix_y = 0;
        @(negedge clk);
        pix_x = 11'd1; pix_y = 10'd0;
        fx = advance(mx, mvx, MH - SZ);
        fy = advance(my, mvy, MV - SZ);
        gx = advance(cx, cvx, CH - SZ);
        gy = advance(cy, cvy, CV - SZ);
        tm = fx ? (oldvx > 0 ? "R4 right edge" : "R5 left edge")
                : (fy ? "R6 vertical edge" : "R8 constant step");
        tc = (gx && gy) ? "R7 corner" : "R8 corner-instance step";
    endtask

    // Whole-frame scan of the main instance, one check per frame.
    task automatic scan(input string tag);
        int bad = 0;
        logic [23:0] firstgot = 0, firstexp = 0;
        for (int y = 0; y < MV; y++) begin
            for (int x = 0; x < MH; x++) begin
                logic [23:0] exp;
                if (x == 0 && y == 0) continue;
                @(negedge clk);
                pix_x = 11'(x); pix_y = 10'(y);
                @(negedge clk);
                exp = (x >= mx && x < mx + SZ && y >= my && y < my + SZ)
                      ? 24'hFFFFFF : 24'h0;
                if (rgb_m != exp) begin
                    if (bad == 0) begin firstgot = rgb_m; firstexp = exp; end
                    bad++;
                end
            end
        end
        check(bad == 0, tag, firstgot, firstexp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        string tm, tc;
        model_reset();
        repeat (3) @(negedge clk);
        // R2: colour is black during reset
        check(rgb_m == 24'h0, "R2 reset colour", rgb_m, 24'h0);
        rst_n = 1;
        // R2: start position, both instances
        probe(0, "R2 start position");
        probe(1, "R2 start position corner");
        scan("R1 full frame at start");

        // R3: x = 0 alone and y = 0 alone do not move the ball
        @(negedge clk); pix_x = 0; pix_y = 10'd7;
        repeat (10) @(negedge clk);
        pix_x = 11'd9; pix_y = 0;
        repeat (10) @(negedge clk);
        probe(0, "R3 no move off origin");

        for (int f = 1; f <= 40; f++) begin
            frame(tm, tc);
            probe(0, tm);
            probe(1, tc);
            if (f == 10 || f == 22 || f == 35) scan("R1/R9 full frame");
        end

        // R2: reset in mid run restores the start state
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check(rgb_m == 24'h0, "R2 mid-run reset colour", rgb_m, 24'h0);
        @(negedge clk); rst_n = 1;
        model_reset();
        probe(0, "R2 restart position");
        frame(tm, tc);
        probe(0, "R2 positive velocity after reset");
        probe(1, "R2 positive velocity after reset corner");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule